// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A purely combinational adder that sums two 16-bit operands and a carry-in. It produces a 16-bit sum and a carry-out. The datapath is split into four 4-bit slices. Each slice derives a generate and a propagate term for every bit. It then resolves all of its internal carries at once with expanded sum-of-products equations, so no carry waits for the bit below it.

Each slice also condenses itself into one group generate and one group propagate. A second-level lookahead unit, built from the same generic carry equation, turns those four pairs into the carry-in of every slice and the final carry-out. The adder also drives its own group generate and group propagate, so a third level can treat it as one slice of a wider adder.

A parameter selects how the lookahead path forms its propagate term: the XOR or the OR of the operand bits. The sum path always uses the XOR.

Top module: `cla_adder`

## Requirements
- R1: For every input combination, {cout, sum} equals a + b + cin, with cout being bit 16 of the 17-bit result.
- R2: The variant built with PROP_OR=1 produces exactly the same sum and cout as the XOR variant for every input.
- R3: The carry entering each 4-bit slice equals the carry out of the addition of all lower bits plus cin. Every carry is formed by a flat AND-OR expression of generate and propagate terms and cin, never from a neighbour's carry output.
- R4: The lowest slice receives cin unchanged: with a = b = 0, sum equals cin and cout is 0.
- R5: grp_p is the AND of all 16 bit propagates. That is &(a ^ b) when PROP_OR=0, and &(a | b) when PROP_OR=1.
- R6: grp_g is 1 exactly when a + b with a carry-in of 0 overflows 16 bits, in both variants.
- R7: cout always equals grp_g | (grp_p & cin).
- R8: A carry born in bit 0 travels through all four slices: a = 16'hFFFF, b = 0, cin = 1 gives sum = 0 and cout = 1. A carry generated in bit 15 alone (a = b = 16'h8000, cin = 0) gives sum = 0 and cout = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |
| grp_p | output | 1 | Group propagate of the whole adder |
| grp_g | output | 1 | Group generate of the whole adder |

## Verification
The hardest situation to reach is a carry that must be passed through every slice by the second-level unit. This only happens when all sixteen bits propagate and the carry is born at the very bottom, and random operands almost never produce it. The stimulus therefore adds directed vectors. These include all-ones plus a carry-in, all-ones plus all-ones, and operands where one slice generates and every slice above it only propagates. Alternating patterns and a long random run are also applied to an XOR and an OR build side by side.

// File: rtl/cla_pkg.sv
package cla_pkg;
   // Width of the full adder result, including the carry-out bit.
   function automatic int result_width(input int slice_w, input int n_slices);
      return slice_w * n_slices + 1;
   endfunction
endpackage

// File: rtl/cla_bit_pg.sv
// Per-bit generate and propagate terms.
module cla_bit_pg #(
   parameter int W       = 4,
   parameter bit PROP_OR = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] gen,
   output logic [W-1:0] prop_sum,
   output logic [W-1:0] prop_la
);
   assign gen      = a & b;
   assign prop_sum = a ^ b;

   generate
      if (PROP_OR) begin : g_or_prop
         assign prop_la = a | b;
      end else begin : g_xor_prop
         assign prop_la = prop_sum;
      end
   endgenerate
endmodule

// File: rtl/cla_lookahead.sv
// Generic flat lookahead unit: every carry is a single AND-OR expression.
module cla_lookahead #(
   parameter int N = 4
) (
   input  logic [N-1:0] gen,
   input  logic [N-1:0] prop,
   input  logic         cin,
   output logic [N:0]   carry,
   output logic         grp_p,
   output logic         grp_g
);
   generate
      if (N < 1) begin : g_bad_n
         $error("cla_lookahead: N must be at least 1");
      end
   endgenerate

   logic term;
   logic acc;
   logic gacc;

   always_comb begin
      carry    = '0;
      carry[0] = cin;
      term     = 1'b0;
      acc      = 1'b0;
      for (int i = 1; i <= N; i++) begin
         acc = 1'b0;
         for (int j = 0; j < i; j++) begin
            term = gen[j];
            for (int k = j + 1; k < i; k++) term = term & prop[k];
            acc = acc | term;
         end
         term = cin;
         for (int k = 0; k < i; k++) term = term & prop[k];
         carry[i] = acc | term;
      end
   end

   always_comb begin
      gacc = 1'b0;
      for (int j = 0; j < N; j++) begin
         logic t;
         t = gen[j];
         for (int k = j + 1; k < N; k++) t = t & prop[k];
         gacc = gacc | t;
      end
      grp_g = gacc;
      grp_p = &prop;
   end

   // Recurrence model used only for checking the flat equations.
   logic [N:0] ripple_ref;
   always_comb begin
      ripple_ref[0] = cin;
      for (int i = 0; i < N; i++)
         ripple_ref[i+1] = gen[i] | (prop[i] & ripple_ref[i]);
   end

   always_comb begin
      // R3
      lookahead_ripple_chk: assert (carry == ripple_ref)
         else $error("flat carries differ from recurrence");
   end
endmodule

// File: rtl/cla_slice.sv
// One lookahead slice: bit terms, flat carries, XOR sum, group outputs.
module cla_slice #(
   parameter int W       = 4,
   parameter bit PROP_OR = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         grp_p,
   output logic         grp_g
);
   logic [W-1:0] gen;
   logic [W-1:0] prop_sum;
   logic [W-1:0] prop_la;
   logic [W:0]   carry;

   cla_bit_pg #(.W(W), .PROP_OR(PROP_OR)) u_pg (
      .a        (a),
      .b        (b),
      .gen      (gen),
      .prop_sum (prop_sum),
      .prop_la  (prop_la)
   );

   cla_lookahead #(.N(W)) u_la (
      .gen   (gen),
      .prop  (prop_la),
      .cin   (cin),
      .carry (carry),
      .grp_p (grp_p),
      .grp_g (grp_g)
   );

   assign sum = prop_sum ^ carry[W-1:0];

   logic [W:0] slice_ref;
   assign slice_ref = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

   always_comb begin
      // R1
      slice_sum_chk: assert (sum == slice_ref[W-1:0])
         else $error("slice sum wrong");
   end
endmodule

// File: rtl/cla_adder.sv
// Two-level carry-lookahead adder: slices plus a second-level lookahead unit.
module cla_adder #(
   parameter int SLICE_W  = 4,
   parameter int N_SLICES = 4,
   parameter bit PROP_OR  = 1'b0
) (
   input  logic [SLICE_W*N_SLICES-1:0] a,
   input  logic [SLICE_W*N_SLICES-1:0] b,
   input  logic                        cin,
   output logic [SLICE_W*N_SLICES-1:0] sum,
   output logic                        cout,
   output logic                        grp_p,
   output logic                        grp_g
);
   import cla_pkg::*;
   localparam int WIDTH = SLICE_W * N_SLICES;
   localparam int RES_W = result_width(SLICE_W, N_SLICES);

   generate
      if (SLICE_W < 1) begin : g_bad_slice_w
         $error("cla_adder: SLICE_W must be at least 1");
      end
      if (N_SLICES < 1) begin : g_bad_n_slices
         $error("cla_adder: N_SLICES must be at least 1");
      end
   endgenerate

   logic [N_SLICES-1:0] slice_p;
   logic [N_SLICES-1:0] slice_g;
   logic [N_SLICES:0]   slice_c;

   genvar s;
   generate
      for (s = 0; s < N_SLICES; s++) begin : g_slice
         cla_slice #(.W(SLICE_W), .PROP_OR(PROP_OR)) u_slice (
            .a     (a[s*SLICE_W +: SLICE_W]),
            .b     (b[s*SLICE_W +: SLICE_W]),
            .cin   (slice_c[s]),
            .sum   (sum[s*SLICE_W +: SLICE_W]),
            .grp_p (slice_p[s]),
            .grp_g (slice_g[s])
         );
      end
   endgenerate

   cla_lookahead #(.N(N_SLICES)) u_lcu (
      .gen   (slice_g),
      .prop  (slice_p),
      .cin   (cin),
      .carry (slice_c),
      .grp_p (grp_p),
      .grp_g (grp_g)
   );

   assign cout = slice_c[N_SLICES];

   logic [RES_W-1:0] total_ref;
   assign total_ref = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

   always_comb begin
      // R1
      total_sum_chk: assert ({cout, sum} == total_ref)
         else $error("adder result wrong");
      // R7
      cout_group_chk: assert (cout == (grp_g | (grp_p & cin)))
         else $error("carry-out disagrees with group terms");
      // R6
      group_gen_chk: assert (!grp_g || cout)
         else $error("group generate without carry-out");
   end
endmodule

// File: tb/tb_cla_adder.sv
module tb_cla_adder;
   localparam int W = 16;

   typedef struct {
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic         cin;
      logic [W:0]   res;
      logic         gp_x;
      logic         gp_o;
      logic         gg;
      string        tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [W-1:0] a, b;
   logic         cin;
   logic [W-1:0] sum_x, sum_o;
   logic         cout_x, cout_o, gp_x, gp_o, gg_x, gg_o;

   cla_adder #(.PROP_OR(1'b0)) dut (
      .a(a), .b(b), .cin(cin), .sum(sum_x), .cout(cout_x),
      .grp_p(gp_x), .grp_g(gg_x)
   );
   cla_adder #(.PROP_OR(1'b1)) dut_or (
      .a(a), .b(b), .cin(cin), .sum(sum_o), .cout(cout_o),
      .grp_p(gp_o), .grp_g(gg_o)
   );

   item_t q[$];
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [W-1:0] va, input logic [W-1:0] vb,
                        input logic vc, input string tag);
      item_t it;
      logic [W:0] nocarry;
      @(posedge clk);
      #1;
      a = va; b = vb; cin = vc;
      it.a = va; it.b = vb; it.cin = vc;
      it.res  = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
      nocarry = {1'b0, va} + {1'b0, vb};
      it.gg   = nocarry[W];
      it.gp_x = &(va ^ vb);
      it.gp_o = &(va | vb);
      it.tag  = tag;
      q.push_back(it);
   endtask

   // Monitor: pop expected items and compare against both builds.
   always @(negedge clk) begin
      if (rst_n && q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         chk({it.tag, "/R1"}, {cout_x, sum_x}, it.res);
         chk("R2", {cout_o, sum_o}, {cout_x, sum_x});
         chk("R5 xor", {{W{1'b0}}, gp_x}, {{W{1'b0}}, it.gp_x});
         chk("R5 or", {{W{1'b0}}, gp_o}, {{W{1'b0}}, it.gp_o});
         chk("R6 xor", {{W{1'b0}}, gg_x}, {{W{1'b0}}, it.gg});
         chk("R6 or", {{W{1'b0}}, gg_o}, {{W{1'b0}}, it.gg});
         chk("R7", {{W{1'b0}}, cout_x}, {{W{1'b0}}, gg_x | (gp_x & it.cin)});
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      a = '0; b = '0; cin = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      drive(16'h0000, 16'h0000, 1'b0, "R1 zero");
      drive(16'h0000, 16'h0000, 1'b1, "R4");
      drive(16'hFFFF, 16'h0000, 1'b1, "R8");
      drive(16'h8000, 16'h8000, 1'b0, "R8 top");
      drive(16'hFFFF, 16'hFFFF, 1'b1, "R1 ones");
      drive(16'hFFFF, 16'hFFFF, 1'b0, "R1 ones");
      drive(16'hAAAA, 16'h5555, 1'b0, "R1 alt");
      drive(16'hAAAA, 16'h5555, 1'b1, "R8 alt");
      drive(16'h5555, 16'h5555, 1'b0, "R1 alt");
      drive(16'hAAAA, 16'hAAAA, 1'b1, "R1 alt");
      // R3: one slice generates, every slice above only propagates
      for (int s = 0; s < 4; s++) begin
         logic [W-1:0] va, vb;
         va = 16'hFFFF;
         vb = 16'h0000;
         vb[s*4] = 1'b1;
         va[s*4] = 1'b1;
         drive(va, vb, 1'b0, "R3 chain");
         drive(16'hFFFF >> (s*4), 16'h0001, 1'b0, "R3 chain");
      end
      for (int i = 0; i < 3000; i++)
         drive(W'($urandom), W'($urandom), 1'($urandom), "R1 rand");
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule